// File: doc/BRIEF.md
# Predicated Pairwise Deinterleave Load

This block carries out one structure load of 16-bit pairs into two vector destinations. A start pulse captures a 64-bit base address, a 4-bit signed vector-length multiplier, a per-pair predicate mask and a destination register number. The block then walks the active pairs. For each one it reads two consecutive halfwords through a single-outstanding request/response memory port. The first halfword of pair i lands in lane i of vector A and the second in lane i of vector B.

Lanes whose predicate bit is clear are zeroed and never touch memory, so a bad address in such a pair cannot fault. When the walk ends the block pulses `done`, with `writeValid` on success. If an active read reports a fault, the walk stops and `done` is pulsed with `faultOut` and the lane index of the failure. The vector length is a parameter (128 to 2048 bits), giving VLEN_BITS/16 lanes.

Top module: `pairwise_deinterleave_load`

## Requirements
- R1: For active pair i, the halfword read at start+4i is placed in lane i of `vecA` (bits 16i+15:16i), and the halfword read at start+4i+2 is placed in lane i of `vecB`.
- R2: The start address is `baseAddr` plus the sign-extended 4-bit `vecImm` (range -8..7) times VLEN_BITS/8, computed modulo 2^64.
- R3: A pair whose `predMask` bit is 0 causes no memory request for either of its halfwords.
- R4: Lanes with a predicate bit of 0 read as zero in both `vecA` and `vecB` when `done` pulses, whatever the vectors held before.
- R5: Requests are issued for active pairs in ascending lane order, with the first halfword before the second, one outstanding at a time.
- R6: On a response with `memRspFault` high, no further request is issued; `done` pulses with `faultOut`=1, `writeValid`=0 and `faultElem` equal to the lane of the failing pair.
- R7: `done` is a one-cycle pulse. With n requests and no fault it is observed 2n+2 cycles after the start cycle (2 for an all-zero mask). With a fault on request n it is observed after 2n+1 cycles. On success `writeValid` accompanies it.
- R8: `dstRegA` equals the captured `destReg`, and `dstRegB` equals `destReg`+1 modulo 32.
- R9: A faulting address inside an inactive pair does not produce a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (accepted when idle) |
| baseAddr | input | 64 | Base byte address |
| vecImm | input | 4 | Signed multiplier of the vector length in bytes |
| predMask | input | VLEN_BITS/16 | One enable bit per pair |
| destReg | input | 5 | First destination register number |
| memReq | output | 1 | Read request strobe |
| memAddr | output | 64 | Halfword byte address of the request |
| memRspValid | input | 1 | Response strobe |
| memRspData | input | 16 | Returned halfword |
| memRspFault | input | 1 | Response carries a fault |
| vecA | output | VLEN_BITS | First halfwords of the pairs |
| vecB | output | VLEN_BITS | Second halfwords of the pairs |
| dstRegA | output | 5 | Register number for vecA |
| dstRegB | output | 5 | Register number for vecB |
| done | output | 1 | End-of-operation pulse |
| writeValid | output | 1 | Results may be written back |
| faultOut | output | 1 | Operation ended on a fault |
| faultElem | output | log2(VLEN_BITS/16) | Lane index of the faulting pair |

## Verification
The bench builds the block with VLEN_BITS=128, which gives eight lanes. At that size the all-active, all-inactive, alternating and single-end masks can each be run as a whole. The scaled offset is 16 bytes per step, so immediates of -8 and 7 push the start address across both ends of the 64-bit space, and the address wrap is checked directly. Faults are placed in an inactive pair, in the second halfword of a middle pair, and in the only active pair, to separate suppression from early stopping.

// File: rtl/pair_load_pkg.sv
package pair_load_pkg;
  localparam int ELEM_W = 16;
  localparam int IMM_W  = 4;
  localparam int REG_W  = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } ldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;       // capture operands, clear lanes
    logic writeHalf;    // store the returned halfword, advance half/pair
    logic captureFault; // remember the failing lane index
  } dpCtrl_t;
endpackage

// File: rtl/pair_load_ctrl.sv
module pair_load_ctrl
  import pair_load_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    remainingAny,
  input  logic    rspValid,
  input  logic    rspFault,
  output dpCtrl_t ctrlStrobe,
  output logic    memReq,
  output logic    done,
  output logic    writeValid,
  output logic    faultOut
);
  ldState_e state, nextState;
  logic finishOk, finishFault;

  always_comb begin
    nextState  = state;
    ctrlStrobe = '0;
    memReq     = 1'b0;
    finishOk   = 1'b0;
    finishFault = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrlStrobe.loadOp = 1'b1;
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!remainingAny) begin
          finishOk  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          memReq    = 1'b1;
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rspValid) begin
          if (rspFault) begin
            ctrlStrobe.captureFault = 1'b1;
            finishFault = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctrlStrobe.writeHalf = 1'b1;
            nextState = ST_ISSUE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      writeValid <= 1'b0;
      faultOut   <= 1'b0;
    end else begin
      state      <= nextState;
      done       <= finishOk | finishFault;
      writeValid <= finishOk;
      faultOut   <= finishFault;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a fault ends the operation without a writeback
  assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> (done && !writeValid));

  // R6: no request follows a faulting response
  assert_fault_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && state == ST_WAIT) |=> !memReq);

  // R5: a request is never issued while one is outstanding
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
endmodule

// File: rtl/pair_load_dp.sv
module pair_load_dp
  import pair_load_pkg::*;
#(
  parameter int VLEN_BITS = 128,
  parameter int ADDR_W    = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpCtrl_t                            ctrlStrobe,
  input  logic                               memReq,
  input  logic [ADDR_W-1:0]                  baseAddr,
  input  logic [IMM_W-1:0]                   vecImm,
  input  logic [VLEN_BITS/ELEM_W-1:0]        predMask,
  input  logic [REG_W-1:0]                   destReg,
  input  logic [ELEM_W-1:0]                  rspData,
  output logic                               remainingAny,
  output logic [ADDR_W-1:0]                  memAddr,
  output logic [VLEN_BITS-1:0]               vecA,
  output logic [VLEN_BITS-1:0]               vecB,
  output logic [REG_W-1:0]                   dstRegA,
  output logic [REG_W-1:0]                   dstRegB,
  output logic [$clog2(VLEN_BITS/ELEM_W)-1:0] faultElem
);
  localparam int NUM_ELEM = VLEN_BITS / ELEM_W;
  localparam int IDX_W    = $clog2(NUM_ELEM);
  localparam int VL_SHIFT = $clog2(VLEN_BITS / 8);

  logic [ADDR_W-1:0]   startAddrQ;
  logic [ADDR_W-1:0]   immScaled;
  logic [NUM_ELEM-1:0] maskQ;
  logic [NUM_ELEM-1:0] remainingQ;
  logic                halfQ;
  logic [IDX_W-1:0]    curIdx;
  logic [REG_W-1:0]    regQ;

  // offset is a whole number of vector lengths; arithmetic wraps at ADDR_W
  assign immScaled = {{(ADDR_W-IMM_W){vecImm[IMM_W-1]}}, vecImm} << VL_SHIFT;

  // lowest pending pair is served first
  always_comb begin
    curIdx = '0;
    for (int k = NUM_ELEM - 1; k >= 0; k--) begin
      if (remainingQ[k]) curIdx = IDX_W'(k);
    end
  end

  assign remainingAny = |remainingQ;
  assign memAddr = startAddrQ + ADDR_W'({curIdx, halfQ, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddrQ <= '0;
      maskQ      <= '0;
      remainingQ <= '0;
      halfQ      <= 1'b0;
      regQ       <= '0;
      faultElem  <= '0;
    end else begin
      if (ctrlStrobe.loadOp) begin
        startAddrQ <= baseAddr + immScaled;
        maskQ      <= predMask;
        remainingQ <= predMask;
        halfQ      <= 1'b0;
        regQ       <= destReg;
      end else if (ctrlStrobe.writeHalf) begin
        halfQ <= ~halfQ;
        if (halfQ) remainingQ[curIdx] <= 1'b0;
      end
      if (ctrlStrobe.captureFault) faultElem <= curIdx;
    end
  end

  assign dstRegA = regQ;
  assign dstRegB = regQ + REG_W'(1);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : gLane
    logic [ELEM_W-1:0] aQ, bQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aQ <= '0;
        bQ <= '0;
      end else if (ctrlStrobe.loadOp) begin
        aQ <= '0;
        bQ <= '0;
      end else if (ctrlStrobe.writeHalf && curIdx == IDX_W'(g)) begin
        if (halfQ) bQ <= rspData;
        else       aQ <= rspData;
      end
    end
    assign vecA[g*ELEM_W +: ELEM_W] = aQ;
    assign vecB[g*ELEM_W +: ELEM_W] = bQ;

    // R4: a disabled lane holds zero in both destinations
    assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!maskQ[g] && !ctrlStrobe.loadOp) |=> (aQ == '0 && bQ == '0));
  end

  // R3: requests only target pairs enabled by the captured mask
  assert_req_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> maskQ[curIdx]);

  // R5: a pair retires only after its second halfword
  assert_pair_retire_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe.writeHalf && halfQ && !ctrlStrobe.loadOp) |=> !remainingQ[$past(curIdx)]);
endmodule

// File: rtl/pairwise_deinterleave_load.sv
module pairwise_deinterleave_load
  import pair_load_pkg::*;
#(
  parameter int VLEN_BITS = 128,
  parameter int ADDR_W    = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [ADDR_W-1:0]                  baseAddr,
  input  logic [IMM_W-1:0]                   vecImm,
  input  logic [VLEN_BITS/ELEM_W-1:0]        predMask,
  input  logic [REG_W-1:0]                   destReg,
  output logic                               memReq,
  output logic [ADDR_W-1:0]                  memAddr,
  input  logic                               memRspValid,
  input  logic [ELEM_W-1:0]                  memRspData,
  input  logic                               memRspFault,
  output logic [VLEN_BITS-1:0]               vecA,
  output logic [VLEN_BITS-1:0]               vecB,
  output logic [REG_W-1:0]                   dstRegA,
  output logic [REG_W-1:0]                   dstRegB,
  output logic                               done,
  output logic                               writeValid,
  output logic                               faultOut,
  output logic [$clog2(VLEN_BITS/ELEM_W)-1:0] faultElem
);
  dpCtrl_t ctrlStrobe;
  logic    remainingAny;

  pair_load_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .remainingAny (remainingAny),
    .rspValid     (memRspValid),
    .rspFault     (memRspFault),
    .ctrlStrobe   (ctrlStrobe),
    .memReq       (memReq),
    .done         (done),
    .writeValid   (writeValid),
    .faultOut     (faultOut)
  );

  pair_load_dp #(
    .VLEN_BITS (VLEN_BITS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlStrobe   (ctrlStrobe),
    .memReq       (memReq),
    .baseAddr     (baseAddr),
    .vecImm       (vecImm),
    .predMask     (predMask),
    .destReg      (destReg),
    .rspData      (memRspData),
    .remainingAny (remainingAny),
    .memAddr      (memAddr),
    .vecA         (vecA),
    .vecB         (vecB),
    .dstRegA      (dstRegA),
    .dstRegB      (dstRegB),
    .faultElem    (faultElem)
  );
endmodule

// File: tb/test_pairwise_deinterleave_load.sv
`timescale 1ns/1ps
module test_pairwise_deinterleave_load;
  localparam int VLEN = 128;
  localparam int NE   = VLEN / 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [63:0] baseAddr = '0;
  logic [3:0]  vecImm = '0;
  logic [NE-1:0] predMask = '0;
  logic [4:0]  destReg = '0;
  logic memReq;
  logic [63:0] memAddr;
  logic memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic memRspFault = 1'b0;
  logic [VLEN-1:0] vecA, vecB;
  logic [4:0] dstRegA, dstRegB;
  logic done, writeValid, faultOut;
  logic [2:0] faultElem;

  int compared = 0;
  int mismatched = 0;
  logic faultEn = 1'b0;
  logic [63:0] faultAddr = '0;
  logic [63:0] reqLog [64];
  int reqCount = 0;

  always #5 clk = ~clk;

  pairwise_deinterleave_load #(.VLEN_BITS(VLEN)) i_pairwise_deinterleave_load (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .vecImm(vecImm),
    .predMask(predMask), .destReg(destReg), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspFault(memRspFault),
    .vecA(vecA), .vecB(vecB), .dstRegA(dstRegA), .dstRegB(dstRegB), .done(done),
    .writeValid(writeValid), .faultOut(faultOut), .faultElem(faultElem));

  function automatic logic [15:0] memVal(input logic [63:0] a);
    return (a[15:0] * 16'd7) ^ a[47:32] ^ 16'h3C5A;
  endfunction

  // memory model: one-cycle response, optional fault at one address
  always @(posedge clk) begin
    memRspValid <= memReq;
    memRspData  <= memVal(memAddr);
    memRspFault <= memReq && faultEn && (memAddr == faultAddr);
    if (memReq) begin
      reqLog[reqCount % 64] <= memAddr;
      reqCount <= reqCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] b, input logic [3:0] imm, input logic [NE-1:0] m,
                       input logic [4:0] dreg, input logic fEn, input logic [63:0] fA,
                       input string tag);
    logic [63:0] s, a;
    logic [VLEN-1:0] expA, expB;
    logic [63:0] expLog [64];
    int expCnt, startCnt, cyc, expCyc;
    logic expFault;
    logic [2:0] expElem;
    bit seqOk;
    s = b + ({{60{imm[3]}}, imm} << 4);
    expA = '0; expB = '0; expCnt = 0; expFault = 1'b0; expElem = '0;
    for (int i = 0; i < NE; i++) begin
      if (m[i]) begin
        for (int h = 0; h < 2; h++) begin
          if (!expFault) begin
            a = s + 64'(4 * i + 2 * h);
            expLog[expCnt] = a;
            expCnt++;
            if (fEn && a == fA) begin
              expFault = 1'b1;
              expElem = 3'(i);
            end else if (h == 0) expA[i*16 +: 16] = memVal(a);
            else                 expB[i*16 +: 16] = memVal(a);
          end
        end
      end
    end
    expCyc = expFault ? 2 * expCnt + 1 : 2 * expCnt + 2;

    @(negedge clk);
    faultEn = fEn; faultAddr = fA;
    baseAddr = b; vecImm = imm; predMask = m; destReg = dreg; start = 1'b1;
    startCnt = reqCount;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R7", {tag, " done seen"}, 128'(done), 128'(1));
    chk(cyc == expCyc, "R7", {tag, " done latency"}, 128'(cyc), 128'(expCyc));
    chk(faultOut === expFault, "R6", {tag, " fault flag"}, 128'(faultOut), 128'(expFault));
    chk(writeValid === !expFault, "R7", {tag, " writeValid"}, 128'(writeValid), 128'(!expFault));
    if (expFault)
      chk(faultElem === expElem, "R6", {tag, " fault lane"}, 128'(faultElem), 128'(expElem));
    else begin
      chk(vecA === expA, "R1", {tag, " vecA (R4 zero lanes)"}, vecA, expA);
      chk(vecB === expB, "R1", {tag, " vecB (R4 zero lanes)"}, vecB, expB);
    end
    chk(dstRegA === dreg && dstRegB === dreg + 5'd1, "R8", {tag, " dest regs"},
        128'({dstRegA, dstRegB}), 128'({dreg, dreg + 5'd1}));
    chk(reqCount - startCnt == expCnt, "R3", {tag, " request count"},
        128'(reqCount - startCnt), 128'(expCnt));
    seqOk = 1'b1;
    for (int k = 0; k < expCnt; k++)
      if (reqLog[(startCnt + k) % 64] !== expLog[k]) seqOk = 1'b0;
    chk(seqOk, "R5", {tag, " request addresses/order (R2)"},
        (expCnt > 0) ? 128'(reqLog[startCnt % 64]) : 128'(0),
        (expCnt > 0) ? 128'(expLog[0]) : 128'(0));
    @(negedge clk);
    chk(done === 1'b0, "R7", {tag, " done pulse width"}, 128'(done), 128'(0));
    faultEn = 1'b0;
  endtask

  localparam logic [63:0] C_BASE [6] = '{64'h0000_0000_0000_1000, 64'h0000_0000_2000_0040,
                                         64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0,
                                         64'h0000_0000_0000_5000, 64'h0000_0000_0000_7000};
  localparam logic [3:0]  C_IMM  [6] = '{4'h0, 4'hF, 4'h8, 4'h7, 4'h2, 4'h3};
  localparam logic [7:0]  C_MASK [6] = '{8'hFF, 8'hA5, 8'h81, 8'h3C, 8'h01, 8'h80};
  localparam logic [4:0]  C_REG  [6] = '{5'd3, 5'd31, 5'd0, 5'd17, 5'd30, 5'd8};

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(done === 1'b0 && writeValid === 1'b0 && faultOut === 1'b0, "R7", "reset flags",
        128'({done, writeValid, faultOut}), 128'(0));
    chk(memReq === 1'b0, "R3", "reset no request", 128'(memReq), 128'(0));
    chk(vecA === '0 && vecB === '0, "R4", "reset vectors", vecA, 128'(0));

    // table walk: R1, R2 (wrap both ways), R4, R5, R8
    for (int c = 0; c < 6; c++)
      runOp(C_BASE[c], C_IMM[c], C_MASK[c], C_REG[c], 1'b0, 64'h0, $sformatf("case%0d", c));

    // all-zero mask straight after a full load: vectors cleared, no reads (R4, R7)
    runOp(64'h0000_0000_0000_1000, 4'h0, 8'hFF, 5'd4, 1'b0, 64'h0, "refill");
    runOp(64'h0000_0000_0000_1000, 4'h0, 8'h00, 5'd4, 1'b0, 64'h0, "zeromask");

    // R9: bad address only in disabled pair 0
    runOp(64'h0000_0000_0000_9000, 4'h0, 8'hFE, 5'd9, 1'b1, 64'h0000_0000_0000_9002, "R9 inactive-fault");
    // R6: fault on second halfword of lane 3
    runOp(64'h0000_0000_0000_A000, 4'h1, 8'hFF, 5'd12, 1'b1, 64'h0000_0000_0000_A01E, "R6 mid-fault");
    // R6: fault on the only active pair
    runOp(64'h0000_0000_0000_B000, 4'h0, 8'h10, 5'd20, 1'b1, 64'h0000_0000_0000_B010, "R6 single-fault");
    // operation after a fault completes normally
    runOp(64'h0000_0000_0000_C000, 4'hE, 8'h5A, 5'd1, 1'b0, 64'h0, "after-fault");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule